// File: doc/BRIEF.md
# Prescaled 8-bit Interval Timer

This block counts upward at a rate taken from the system clock through a power-of-two divider. A 3-bit rate code selects the divider. When the count rolls over from its top value to zero, the block raises a sticky interrupt request, provided that the request is enabled. The count is not reloaded after a rollover. It keeps counting from zero until software writes a new value.

Software sets the interval as follows. While the timer is stopped, it writes a start value `v`. It then raises the run enable. The request rises `div × (256 − v)` clock cycles later, plus one cycle for the start. A small two-state controller handles run control. State `ST_STOP` holds the prescaler at zero and freezes the count. State `ST_COUNT` lets the prescaler run and the count advance. The transition START (`ST_STOP` to `ST_COUNT`) is taken on a clock edge where `run_en` is 1. The transition HALT (`ST_COUNT` to `ST_STOP`) is taken on an edge where `run_en` is 0.

Top module: `tmr8_interval_timer`

## Requirements
- R1: After reset, `cnt_rdata` is 0x00, `irq_flag` is 0, and the controller is in `ST_STOP`.
- R2: The rate code sets the divider to 256 >> `rate_sel`, so code 0 is /256 and code 7 is /2. The first increment comes `div` edges after the START edge, and later increments follow every `div` edges. Each count step is one single-cycle strobe.
- R3: When an increment meets a count of 0xFF, the count becomes 0x00 and an overflow event occurs. Counting then continues upward from 0x00 with no reload.
- R4: An overflow sets `irq_flag` only if `irq_en` is 1 on that edge. When `irq_en` is 0, the flag is left unchanged.
- R5: `irq_flag` stays at 1 until an edge where `flag_clr` is 1. If a clear and an enabled overflow fall on the same edge, the flag is 1 afterwards.
- R6: When `cnt_wr` is 1, the count takes `cnt_wdata` at that edge, even if an increment falls on the same edge, and no overflow is raised. A write never changes `irq_flag`. Writes also work while the timer is stopped.
- R7: While the controller is in `ST_STOP`, the count holds its value and the prescaler stays at zero. After each START, the prescaler begins again from zero.
- R8: If `v` is loaded while the timer is stopped and `run_en` is then raised, `irq_flag` (with `irq_en` = 1) rises on rising edge number `div × (256 − v) + 1` after `run_en` is driven high. The count reads 0x00 at that point.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| run_en | input | 1 | Timer run enable |
| rate_sel | input | 3 | Divider code, divider = 256 >> code |
| irq_en | input | 1 | Allows an overflow to set the request flag |
| cnt_wr | input | 1 | Load strobe for the count |
| cnt_wdata | input | 8 | Value to load |
| flag_clr | input | 1 | Clear strobe for the request flag |
| cnt_rdata | output | 8 | Live count value |
| irq_flag | output | 1 | Sticky overflow request |

## Verification
The hardest cases to reach are the ones where two edge events coincide. The first is a flag clear landing on the same edge as an overflow. The second is a count write landing on the same edge as a prescaler strobe. The bench reaches both with the fastest rate (/2) and a preload of 0xFF, which puts the overflow exactly two edges after START. That lets the clear strobe be placed on the colliding edge on purpose. The bench also holds two back-to-back writes across one strobe period. A behavioural reference model runs alongside and is compared on every cycle. It catches any disagreement across the long period sweeps for all eight rate codes.

// File: rtl/tmr8_pkg.sv
package tmr8_pkg;

    typedef enum logic [0:0] {
        ST_STOP  = 1'b0,
        ST_COUNT = 1'b1
    } run_state_t;

endpackage

// File: rtl/tmr8_prescaler.sv
module tmr8_prescaler #(
    parameter int PRE_W = 8,
    parameter int SEL_W = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clear,
    input  logic [SEL_W-1:0] rate_sel,
    output logic             tick
);
    localparam int NCODES = 1 << SEL_W;

    logic [PRE_W-1:0]  pre_q;
    logic [NCODES-1:0] hit;

    // Each rate code compares a different number of low bits with all-ones.
    generate
        for (genvar g = 0; g < NCODES; g++) begin : g_rate
            localparam logic [PRE_W-1:0] MASK = {PRE_W{1'b1}} >> g;
            assign hit[g] = (pre_q & MASK) == MASK;
        end
    endgenerate

    assign tick = !clear && hit[rate_sel];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pre_q <= '0;
        end else if (clear) begin
            pre_q <= '0;
        end else begin
            pre_q <= pre_q + 1'b1;
        end
    end

    AST_TICK_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        tick |=> !tick); // R2

    AST_PRE_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        clear |=> (pre_q == '0)); // R7

endmodule

// File: rtl/tmr8_counter.sv
module tmr8_counter #(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick,
    input  logic             wr_en,
    input  logic [CNT_W-1:0] wr_data,
    output logic [CNT_W-1:0] cnt,
    output logic             ovf
);
    logic [CNT_W-1:0] cnt_q;

    assign cnt = cnt_q;
    assign ovf = tick && !wr_en && (cnt_q == {CNT_W{1'b1}});

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (wr_en) begin
            cnt_q <= wr_data;
        end else if (tick) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    AST_WR_PRIO: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> (cnt_q == $past(wr_data))); // R6

    AST_WRAP_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        ovf |=> (cnt_q == '0)); // R3

endmodule

// File: rtl/tmr8_flag.sv
module tmr8_flag (
    input  logic clk,
    input  logic rst_n,
    input  logic ovf,
    input  logic irq_en,
    input  logic clr,
    output logic flag
);
    logic flag_q;
    logic set_req;

    assign set_req = ovf && irq_en;
    assign flag    = flag_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            flag_q <= 1'b0;
        end else if (set_req) begin
            flag_q <= 1'b1;
        end else if (clr) begin
            flag_q <= 1'b0;
        end
    end

    AST_FLAG_SUPPRESS: assert property (@(posedge clk) disable iff (!rst_n)
        (!flag_q && !irq_en) |=> !flag_q); // R4

    AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (flag_q && !clr) |=> flag_q); // R5

    AST_SET_BEATS_CLR: assert property (@(posedge clk) disable iff (!rst_n)
        (ovf && irq_en && clr) |=> flag_q); // R5

endmodule

// File: rtl/tmr8_interval_timer.sv
module tmr8_interval_timer
    import tmr8_pkg::*;
#(
    parameter int CNT_W = 8,
    parameter int PRE_W = 8,
    parameter int SEL_W = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run_en,
    input  logic [SEL_W-1:0] rate_sel,
    input  logic             irq_en,
    input  logic             cnt_wr,
    input  logic [CNT_W-1:0] cnt_wdata,
    input  logic             flag_clr,
    output logic [CNT_W-1:0] cnt_rdata,
    output logic             irq_flag
);
    run_state_t state_q, state_d;
    logic       pre_clear;
    logic       tick;
    logic       ovf;

    // Next-state logic: START and HALT transitions
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_STOP:  if (run_en)  state_d = ST_COUNT;
            ST_COUNT: if (!run_en) state_d = ST_STOP;
            default:  state_d = ST_STOP;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_STOP;
        end else begin
            state_q <= state_d;
        end
    end

    // Output decode from state
    always_comb begin
        unique case (state_q)
            ST_STOP:  pre_clear = 1'b1;
            ST_COUNT: pre_clear = 1'b0;
            default:  pre_clear = 1'b1;
        endcase
    end

    tmr8_prescaler #(.PRE_W(PRE_W), .SEL_W(SEL_W)) u_pre (
        .clk      (clk),
        .rst_n    (rst_n),
        .clear    (pre_clear),
        .rate_sel (rate_sel),
        .tick     (tick)
    );

    tmr8_counter #(.CNT_W(CNT_W)) u_cnt (
        .clk     (clk),
        .rst_n   (rst_n),
        .tick    (tick),
        .wr_en   (cnt_wr),
        .wr_data (cnt_wdata),
        .cnt     (cnt_rdata),
        .ovf     (ovf)
    );

    tmr8_flag u_flag (
        .clk    (clk),
        .rst_n  (rst_n),
        .ovf    (ovf),
        .irq_en (irq_en),
        .clr    (flag_clr),
        .flag   (irq_flag)
    );

    AST_HALT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_STOP && !cnt_wr) |=> $stable(cnt_rdata)); // R7

    AST_STOP_NO_TICK: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_STOP) |-> !tick); // R7

    AST_START: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_STOP && run_en) |=> (state_q == ST_COUNT)); // R7

endmodule

// File: tb/tb_tmr8_interval_timer.sv
module tb_tmr8_interval_timer;

    logic       clk = 1'b0;
    logic       rst_n;
    logic       run_en;
    logic [2:0] rate_sel;
    logic       irq_en;
    logic       cnt_wr;
    logic [7:0] cnt_wdata;
    logic       flag_clr;
    logic [7:0] cnt_rdata;
    logic       irq_flag;

    int total = 0;
    int bad   = 0;
    bit done  = 1'b0;

    // reference model state
    bit m_run  = 1'b0;
    int m_pre  = 0;
    int m_cnt  = 0;
    bit m_flag = 1'b0;

    always #10 clk = ~clk;

    tmr8_interval_timer dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .run_en    (run_en),
        .rate_sel  (rate_sel),
        .irq_en    (irq_en),
        .cnt_wr    (cnt_wr),
        .cnt_wdata (cnt_wdata),
        .flag_clr  (flag_clr),
        .cnt_rdata (cnt_rdata),
        .irq_flag  (irq_flag)
    );

    task automatic chk(input string tag, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
        end
    endtask

    // Behavioural model, advanced on every rising edge
    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            m_run = 1'b0; m_pre = 0; m_cnt = 0; m_flag = 1'b0;
        end else begin
            int  div;
            bit  stp;
            bit  wrap;
            div  = 256 >> rate_sel;
            stp  = m_run && ((m_pre % div) == div - 1);
            wrap = stp && !cnt_wr && (m_cnt == 255);
            if (cnt_wr)   m_cnt = int'(cnt_wdata);
            else if (stp) m_cnt = (m_cnt + 1) % 256;
            if (wrap && irq_en) m_flag = 1'b1;
            else if (flag_clr)  m_flag = 1'b0;
            m_pre = m_run ? (m_pre + 1) % 256 : 0;
            m_run = run_en;
        end
    end

    // Per-cycle comparison, away from the active edge
    always @(negedge clk) begin
        if (!done) begin
            chk("R2 model count", int'(cnt_rdata), m_cnt);
            chk("R4 model flag", int'(irq_flag), int'(m_flag));
        end
    end

    task automatic measure(input int r, input int v);
        int n;
        int div;
        div = 256 >> r;
        @(negedge clk);
        run_en = 1'b0; irq_en = 1'b1; cnt_wr = 1'b1; cnt_wdata = 8'(v); flag_clr = 1'b1;
        @(negedge clk);
        cnt_wr = 1'b0; flag_clr = 1'b0; rate_sel = 3'(r); run_en = 1'b1;
        n = 0;
        do begin
            @(posedge clk);
            n++;
            @(negedge clk);
        end while (!irq_flag && n < 70000);
        chk($sformatf("R2 R8 period rate=%0d v=%0d", r, v), n, div * (256 - v) + 1);
        chk("R3 wrap to zero", int'(cnt_rdata), 0);
        repeat (div) @(negedge clk);
        chk("R3 continues after wrap", int'(cnt_rdata), 1);
        chk("R5 flag held", int'(irq_flag), 1);
    endtask

    initial begin
        int c;
        rst_n = 1'b0; run_en = 1'b0; rate_sel = 3'd0; irq_en = 1'b0;
        cnt_wr = 1'b0; cnt_wdata = 8'h00; flag_clr = 1'b0;
        repeat (3) @(negedge clk);
        chk("R1 reset count", int'(cnt_rdata), 0);
        chk("R1 reset flag", int'(irq_flag), 0);
        rst_n = 1'b1;

        // write while stopped, then hold
        @(negedge clk); cnt_wr = 1'b1; cnt_wdata = 8'h5A;
        @(negedge clk); cnt_wr = 1'b0;
        repeat (20) @(negedge clk);
        chk("R6 R7 stopped write held", int'(cnt_rdata), 'h5A);

        // periods for every rate code
        for (int r = 0; r < 8; r++) begin
            measure(r, 'h74);
            measure(r, 'hFF);
        end
        measure(7, 0);
        measure(6, 0);

        // suppression with irq_en low at /2
        @(negedge clk);
        run_en = 1'b0; irq_en = 1'b0; cnt_wr = 1'b1; cnt_wdata = 8'hFE; flag_clr = 1'b1;
        @(negedge clk);
        cnt_wr = 1'b0; flag_clr = 1'b0; rate_sel = 3'd7; run_en = 1'b1;
        repeat (20) @(negedge clk);
        chk("R4 flag suppressed", int'(irq_flag), 0);
        chk("R3 count past wrap", int'(cnt_rdata), 7);

        // set flag with a quick overflow
        run_en = 1'b0; cnt_wr = 1'b1; cnt_wdata = 8'hFF; irq_en = 1'b1;
        @(negedge clk); cnt_wr = 1'b0; run_en = 1'b1;
        repeat (3) @(negedge clk);
        chk("R4 flag set when enabled", int'(irq_flag), 1);

        // clear colliding with overflow
        run_en = 1'b0; cnt_wr = 1'b1; cnt_wdata = 8'hFF;
        @(negedge clk); cnt_wr = 1'b0; run_en = 1'b1;
        @(negedge clk);
        @(negedge clk); flag_clr = 1'b1;
        @(negedge clk); flag_clr = 1'b0;
        chk("R5 set wins over clear", int'(irq_flag), 1);
        chk("R3 collision wrap", int'(cnt_rdata), 0);
        flag_clr = 1'b1;
        @(negedge clk); flag_clr = 1'b0;
        chk("R5 clear alone", int'(irq_flag), 0);

        // write priority over a strobe
        cnt_wr = 1'b1; cnt_wdata = 8'hFF;
        @(negedge clk);
        @(negedge clk); cnt_wr = 1'b0;
        chk("R6 write beats increment", int'(cnt_rdata), 'hFF);
        chk("R6 no overflow on write", int'(irq_flag), 0);
        repeat (4) @(negedge clk);
        chk("R4 overflow after write", int'(irq_flag), 1);
        cnt_wr = 1'b1; cnt_wdata = 8'h33;
        @(negedge clk); cnt_wr = 1'b0;
        chk("R6 write value", int'(cnt_rdata), 'h33);
        chk("R6 write keeps flag", int'(irq_flag), 1);

        // halt holds count
        run_en = 1'b0;
        @(negedge clk);
        c = int'(cnt_rdata);
        repeat (30) @(negedge clk);
        chk("R7 halted count held", int'(cnt_rdata), c);

        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            total++;
            bad++;
            $display("FAIL watchdog R8 actual=%0d expected=%0d", 1, 0);
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

endmodule